// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a small in-order integer core with five stages: fetch, decode, execute, memory access and writeback. It runs a six-type instruction set: register-register ALU, ALU with immediate, load, store, absolute jump and branch-if-equal. Instruction memory and data memory are reached through separate ports. Both ports read combinationally. A data-memory write takes effect on the clock edge that ends the memory-access cycle. An external stall input stops fetching for as long as it is held.

Control transfers are resolved in decode. Fetch always assumes fall-through, so a taken jump or branch discards the single instruction fetched behind it. Decode reads its operands through a forwarding network fed by execute, memory and writeback. It therefore sees the register values that would exist once all three older instructions have finished. The one exception is a load still in execute: its consumer is held in decode for one cycle. A one-bit retire output reports, each cycle, whether a new instruction was accepted into the architectural stream.

Top module: `pipe5_core`

## Requirements
- R1: An instruction word holds, from bit 31 down, a 4-bit opcode, rd (3 bits), rs1 (3 bits), rs2 (3 bits), a 3-bit function code and a 16-bit immediate. The immediate is sign-extended to 32 bits.
  - Opcodes: 0 is ALU (rd = rs1 op rs2), 1 is ALU-immediate (rd = rs1 op imm), 2 is load, 3 is store, 4 is jump, 5 is branch. Any other opcode does nothing.
  - Function codes: 0 is add, 1 is subtract (rs1 minus operand), 2 is AND, 3 is OR and 4 is XOR. Any other function code adds.
- R2: Load and store form their address as rs1 plus imm, and take its low address bits. A store writes rs2 to that address. A load writes the word read at that address to rd.
- R3: An instruction that depends on an ALU result computed one, two or three instructions earlier receives the new value without losing a cycle.
- R4: When the instruction in decode reads a register that a load now in execute will write, it is held for exactly one cycle. During that cycle the fetch address repeats. The instruction then receives the loaded value.
- R5: Jump, and branch with rs1 equal to rs2, set the PC to the low bits of imm. The instruction fetched right behind either one is discarded. The target appears on the fetch address two cycles after the jump or branch was fetched. A branch whose operands differ falls through.
- R6: While stall is high, the fetch address holds and no instruction is accepted. Instructions already past fetch keep moving.
- R7: If stall is held long enough, every older instruction completes, including its store. No further data-memory write occurs until fetching resumes.
- R8: Store, jump and branch never write the register file, whatever their rd field holds.
- R9: Register 0 reads as zero, and writes to it are discarded.
- R10: retire_cnt is 0 in a cycle with a load interlock, an asserted stall or a taken jump or branch. In every other cycle it is 1.
- R11: After reset the fetch address is 0, the pipeline is empty, no data-memory write is issued and the register file holds zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Suppresses fetch while high |
| imem_addr | output | PC_W | Instruction fetch address (word index) |
| imem_rdata | input | 32 | Instruction at imem_addr, same cycle |
| dmem_addr | output | DA_W | Data-memory word address |
| dmem_we | output | 1 | Data-memory write strobe |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Word at dmem_addr, same cycle |
| retire_cnt | output | 1 | Instructions accepted this cycle (0 or 1) |

## Verification
Timing is counted in cycles from the first cycle after reset, starting at cycle 0. An instruction fetched in cycle k is decoded in k+1, executed in k+2 and makes its memory access in k+3, so its store lands on the edge that closes k+3. A redirect shows up on imem_addr in cycle k+2, and an interlock repeats the fetch address in the cycle after decode sees the conflict. The bench samples imem_addr, dmem_we and retire_cnt one time unit after each falling edge and indexes them by cycle. Each trace check therefore names the exact cycle in which the value is due. Architectural results are read from the bench's data-memory model once each program has drained.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

    localparam int unsigned XLEN  = 32;
    localparam int unsigned RAW   = 3;
    localparam int unsigned IMM_W = 16;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [RAW-1:0]  reg_t;

    typedef enum logic [3:0] {
        OP_ALU  = 4'd0,
        OP_ALUI = 4'd1,
        OP_LD   = 4'd2,
        OP_ST   = 4'd3,
        OP_JMP  = 4'd4,
        OP_BR   = 4'd5
    } op_e;

    typedef enum logic [2:0] {
        FN_ADD = 3'd0,
        FN_SUB = 3'd1,
        FN_AND = 3'd2,
        FN_OR  = 3'd3,
        FN_XOR = 3'd4
    } fn_e;

    typedef struct packed {
        op_e              op;
        reg_t             rd;
        reg_t             rs1;
        reg_t             rs2;
        fn_e              fn;
        logic [IMM_W-1:0] imm;
    } instr_t;

    localparam int unsigned ILEN = $bits(instr_t);

    typedef struct packed {
        logic  valid;
        logic  is_ld;
        logic  is_st;
        fn_e   fn;
        reg_t  rd;
        word_t opa;
        word_t opb;
        word_t sdata;
    } idex_t;

    typedef struct packed {
        logic  valid;
        logic  is_ld;
        logic  is_st;
        reg_t  rd;
        word_t res;
        word_t sdata;
    } exmem_t;

    typedef struct packed {
        logic  valid;
        reg_t  rd;
        word_t res;
    } memwb_t;

    function automatic word_t alu_f(fn_e fn, word_t a, word_t b);
        case (fn)
            FN_SUB:  return a - b;
            FN_AND:  return a & b;
            FN_OR:   return a | b;
            FN_XOR:  return a ^ b;
            default: return a + b;
        endcase
    endfunction

endpackage

// File: rtl/pipe5_rf.sv
module pipe5_rf
    import pipe5_pkg::*;
#(
    parameter int unsigned NREG = 1 << RAW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0][RAW-1:0] raddr,
    output word_t [1:0]         rdata,
    input  logic                we,
    input  reg_t                waddr,
    input  word_t               wdata
);

    word_t regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(NREG); i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_rd
        assign rdata[g] = (raddr[g] == '0) ? '0 : regs[raddr[g]];
    end

endmodule

// File: rtl/pipe5_fwd.sv
module pipe5_fwd
    import pipe5_pkg::*;
(
    input  logic [1:0][RAW-1:0] src,
    input  logic [1:0]          src_used,
    input  word_t [1:0]         rf_val,
    input  reg_t                ex_rd,
    input  logic                ex_ld,
    input  word_t               ex_val,
    input  reg_t                mem_rd,
    input  word_t               mem_val,
    input  reg_t                wb_rd,
    input  word_t               wb_val,
    output word_t [1:0]         opnd,
    output logic                load_hazard
);

    logic [1:0] hz;

    for (genvar g = 0; g < 2; g++) begin : g_src
        word_t sel;
        always_comb begin
            if (ex_rd != '0 && ex_rd == src[g])        sel = ex_val;
            else if (mem_rd != '0 && mem_rd == src[g]) sel = mem_val;
            else if (wb_rd != '0 && wb_rd == src[g])   sel = wb_val;
            else                                       sel = rf_val[g];
        end
        assign opnd[g] = sel;
        assign hz[g]   = src_used[g] && ex_ld && ex_rd != '0 && ex_rd == src[g];
    end

    assign load_hazard = |hz;

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int unsigned PC_W = 8,
    parameter int unsigned DA_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stall,
    output logic [PC_W-1:0] imem_addr,
    input  logic [ILEN-1:0] imem_rdata,
    output logic [DA_W-1:0] dmem_addr,
    output logic            dmem_we,
    output logic [XLEN-1:0] dmem_wdata,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic            retire_cnt
);

    localparam int unsigned EXT_W = XLEN - IMM_W;

    // ---------------- state ----------------
    logic [PC_W-1:0] pc_q, pc_d;
    logic            ifid_valid_q, ifid_valid_d;
    logic [ILEN-1:0] ifid_instr_q, ifid_instr_d;
    idex_t           idex_q, idex_d;
    exmem_t          exmem_q;
    memwb_t          memwb_q;
    logic            stall_q;

    // ---------------- decode ----------------
    instr_t      id_i;
    word_t       id_imm;
    logic [1:0]  id_use;
    word_t [1:0] rf_val;
    word_t [1:0] opnd;
    logic        load_hazard;
    logic        interlock, id_go, taken;
    word_t       ex_val, mem_val;

    assign id_i   = instr_t'(ifid_instr_q);
    assign id_imm = {{EXT_W{id_i.imm[IMM_W-1]}}, id_i.imm};

    always_comb begin
        case (id_i.op)
            OP_ALU, OP_ST, OP_BR: id_use = 2'b11;
            OP_ALUI, OP_LD:       id_use = 2'b01;
            default:              id_use = 2'b00;
        endcase
    end

    assign ex_val  = alu_f(idex_q.fn, idex_q.opa, idex_q.opb);
    assign mem_val = exmem_q.is_ld ? dmem_rdata : exmem_q.res;

    pipe5_rf u_rf (
        .clk   (clk),
        .rst   (rst),
        .raddr ({id_i.rs2, id_i.rs1}),
        .rdata (rf_val),
        .we    (memwb_q.valid && memwb_q.rd != '0),
        .waddr (memwb_q.rd),
        .wdata (memwb_q.res)
    );

    pipe5_fwd u_fwd (
        .src         ({id_i.rs2, id_i.rs1}),
        .src_used    (id_use),
        .rf_val      (rf_val),
        .ex_rd       (idex_q.rd),
        .ex_ld       (idex_q.is_ld),
        .ex_val      (ex_val),
        .mem_rd      (exmem_q.rd),
        .mem_val     (mem_val),
        .wb_rd       (memwb_q.rd),
        .wb_val      (memwb_q.res),
        .opnd        (opnd),
        .load_hazard (load_hazard)
    );

    assign interlock = ifid_valid_q && load_hazard;
    assign id_go     = ifid_valid_q && !load_hazard;
    assign taken     = id_go && (id_i.op == OP_JMP ||
                                 (id_i.op == OP_BR && opnd[0] == opnd[1]));

    // next PC and fetch/decode register
    always_comb begin
        if (taken)                  pc_d = id_imm[PC_W-1:0];
        else if (interlock || stall) pc_d = pc_q;
        else                        pc_d = pc_q + PC_W'(1);

        if (interlock) begin
            ifid_valid_d = ifid_valid_q;
            ifid_instr_d = ifid_instr_q;
        end else if (taken || stall) begin
            ifid_valid_d = 1'b0;
            ifid_instr_d = ifid_instr_q;
        end else begin
            ifid_valid_d = 1'b1;
            ifid_instr_d = imem_rdata;
        end
    end

    // decode -> execute: non-writing slots carry rd = 0
    always_comb begin
        idex_d = '0;
        if (id_go) begin
            case (id_i.op)
                OP_ALU: begin
                    idex_d.valid = 1'b1;
                    idex_d.fn    = id_i.fn;
                    idex_d.rd    = id_i.rd;
                    idex_d.opa   = opnd[0];
                    idex_d.opb   = opnd[1];
                end
                OP_ALUI: begin
                    idex_d.valid = 1'b1;
                    idex_d.fn    = id_i.fn;
                    idex_d.rd    = id_i.rd;
                    idex_d.opa   = opnd[0];
                    idex_d.opb   = id_imm;
                end
                OP_LD: begin
                    idex_d.valid = 1'b1;
                    idex_d.is_ld = 1'b1;
                    idex_d.rd    = id_i.rd;
                    idex_d.opa   = opnd[0];
                    idex_d.opb   = id_imm;
                end
                OP_ST: begin
                    idex_d.valid = 1'b1;
                    idex_d.is_st = 1'b1;
                    idex_d.opa   = opnd[0];
                    idex_d.opb   = id_imm;
                    idex_d.sdata = opnd[1];
                end
                default: idex_d = '0;
            endcase
        end
    end

    // ---------------- stage registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q         <= '0;
            ifid_valid_q <= 1'b0;
            ifid_instr_q <= '0;
            idex_q       <= '0;
            exmem_q      <= '0;
            memwb_q      <= '0;
            stall_q      <= 1'b0;
        end else begin
            pc_q          <= pc_d;
            ifid_valid_q  <= ifid_valid_d;
            ifid_instr_q  <= ifid_instr_d;
            idex_q        <= idex_d;
            exmem_q.valid <= idex_q.valid;
            exmem_q.is_ld <= idex_q.is_ld;
            exmem_q.is_st <= idex_q.is_st;
            exmem_q.rd    <= idex_q.rd;
            exmem_q.res   <= ex_val;
            exmem_q.sdata <= idex_q.sdata;
            memwb_q.valid <= exmem_q.valid;
            memwb_q.rd    <= exmem_q.rd;
            memwb_q.res   <= mem_val;
            stall_q       <= stall;
        end
    end

    // ---------------- outputs ----------------
    assign imem_addr  = pc_q;
    assign dmem_addr  = exmem_q.res[DA_W-1:0];
    assign dmem_we    = exmem_q.valid && exmem_q.is_st;
    assign dmem_wdata = exmem_q.sdata;
    assign retire_cnt = !(interlock || stall || taken);

    // ---------------- assertions ----------------
    p_bubble_dest_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (!idex_q.valid || idex_q.is_st) |-> idex_q.rd == '0);

    p_interlock_hold_r4: assert property (@(posedge clk) disable iff (rst)
        interlock |=> (!idex_q.valid && ifid_valid_q && $stable(ifid_instr_q) && !interlock));

    p_taken_squash_r5: assert property (@(posedge clk) disable iff (rst)
        taken |=> !ifid_valid_q);

    p_stall_pc_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (stall && !taken) |=> $stable(pc_q));

    p_two_stall_empty_r7: assert property (@(posedge clk) disable iff (rst)
        (stall && stall_q) |=> !ifid_valid_q);

    p_retire_fills_r10: assert property (@(posedge clk) disable iff (rst)
        retire_cnt |=> ifid_valid_q);

    p_store_needs_valid_r2: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> $past(idex_q.is_st));

endmodule

// File: tb/pipe5_core_tb.sv
`timescale 1ns/1ps
module pipe5_core_tb;

    localparam logic [3:0] O_ALU = 4'd0, O_ALUI = 4'd1, O_LD = 4'd2,
                           O_ST = 4'd3, O_JMP = 4'd4, O_BR = 4'd5;
    localparam logic [31:0] SENT = 32'hDEAD_BEEF;
    localparam int NV = 8;

    // stimulus/expected table: function code, a, b, expected result
    localparam logic [2:0]  T_FN  [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd2, 3'd6, 3'd1};
    localparam int          T_A   [NV] = '{5, 3, 3855, 3840, 32767, -256, 100, -32768};
    localparam int          T_B   [NV] = '{7, 10, 255, 240, 3855, 4080, 23, 1};
    localparam logic [31:0] T_EXP [NV] = '{32'h0000_000C, 32'hFFFF_FFF9, 32'h0000_000F,
                                           32'h0000_0FF0, 32'h0000_70F0, 32'h0000_0F00,
                                           32'h0000_007B, 32'hFFFF_7FFF};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0;
    logic [7:0]  imem_addr;
    logic [31:0] imem_rdata;
    logic [7:0]  dmem_addr;
    logic        dmem_we;
    logic [31:0] dmem_wdata;
    logic [31:0] dmem_rdata;
    logic        retire_cnt;

    logic [31:0] imem [256];
    logic [31:0] dmem [256];

    int          nvec = 0;
    int          nfail = 0;
    int          zeros;
    logic [7:0]  tr_pc [64];
    logic        tr_we [64];
    logic [31:0] probe;

    always #4 clk = ~clk;

    pipe5_core u_dut (
        .clk        (clk),
        .rst        (rst),
        .stall      (stall),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_we    (dmem_we),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata),
        .retire_cnt (retire_cnt)
    );

    assign imem_rdata = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

    function automatic logic [31:0] enc(logic [3:0] op, int rd, int rs1, int rs2,
                                        logic [2:0] fn, int imm);
        return {op, 3'(rd), 3'(rs1), 3'(rs2), fn, 16'(imm)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) begin
            imem[i] = 32'h0;
            dmem[i] = SENT;
        end
    endtask

    // reset, then run ncyc cycles; stall high in cycles [s0, s0+sl); probe dmem at cycle pcyc
    task automatic run(input int ncyc, input int s0, input int sl, input int pcyc, input int paddr);
        zeros = 0;
        stall = 1'b0;
        rst   = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < ncyc; c++) begin
            stall = (c >= s0) && (c < s0 + sl);
            #1;
            if (!retire_cnt) zeros++;
            tr_pc[c] = imem_addr;
            tr_we[c] = dmem_we;
            if (c == pcyc) probe = dmem[paddr];
            @(negedge clk);
        end
        stall = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        // ---- ALU table with back-to-back dependences (R1, R3, R11) ----
        clear_mem();
        for (int i = 0; i < NV; i++) begin
            imem[6*i+0] = enc(O_ALUI, 1, 0, 0, 3'd0, T_A[i]);
            imem[6*i+1] = enc(O_ALUI, 2, 0, 0, 3'd0, T_B[i]);
            imem[6*i+2] = enc(O_ALU,  3, 1, 2, T_FN[i], 0);
            imem[6*i+3] = enc(O_ST,   0, 0, 3, 3'd0, 64 + i);
            imem[6*i+4] = enc(O_ALUI, 4, 1, 0, T_FN[i], T_B[i]);
            imem[6*i+5] = enc(O_ST,   0, 0, 4, 3'd0, 96 + i);
        end
        run(60, 99, 0, 99, 0);
        chk("R11 fetch address after reset", 32'(tr_pc[0]), 32'h0);
        chk("R11 no write after reset", 32'(tr_we[0]), 32'h0);
        chk("R11/R10 retire in first cycle", 32'(zeros), 32'h0);
        for (int i = 0; i < NV; i++) begin
            chk($sformatf("R1/R3 reg-reg vector %0d", i), dmem[64+i], T_EXP[i]);
            chk($sformatf("R1/R3 immediate vector %0d", i), dmem[96+i], T_EXP[i]);
        end

        // ---- load-use interlock (R2, R4, R10) ----
        clear_mem();
        imem[0] = enc(O_ALUI, 1, 0, 0, 3'd0, 5);
        imem[1] = enc(O_ST,   0, 0, 1, 3'd0, 10);
        imem[2] = enc(O_LD,   2, 0, 0, 3'd0, 10);
        imem[3] = enc(O_ALU,  3, 2, 2, 3'd0, 0);
        imem[4] = enc(O_ST,   0, 0, 3, 3'd0, 11);
        run(20, 99, 0, 99, 0);
        chk("R2 store data", dmem[10], 32'd5);
        chk("R4 loaded value reaches consumer", dmem[11], 32'd10);
        chk("R4 fetch address in interlock cycle", 32'(tr_pc[4]), 32'd4);
        chk("R4 fetch address repeats", 32'(tr_pc[5]), 32'd4);
        chk("R10 one zero for one interlock", 32'(zeros), 32'd1);

        // ---- taken branch (R5, R3, R10) ----
        clear_mem();
        imem[0] = enc(O_ALUI, 1, 0, 0, 3'd0, 3);
        imem[1] = enc(O_ALUI, 2, 0, 0, 3'd0, 3);
        imem[2] = enc(O_BR,   0, 1, 2, 3'd0, 8);
        imem[3] = enc(O_ST,   0, 0, 1, 3'd0, 20);
        imem[8] = enc(O_ST,   0, 0, 2, 3'd0, 21);
        run(20, 99, 0, 99, 0);
        chk("R5 fall-through fetch before resolve", 32'(tr_pc[3]), 32'd3);
        chk("R5 target on fetch address", 32'(tr_pc[4]), 32'd8);
        chk("R5 squashed store absent", dmem[20], SENT);
        chk("R5 target store", dmem[21], 32'd3);
        chk("R10 one zero for taken branch", 32'(zeros), 32'd1);

        // ---- not-taken branch and jump (R5, R10) ----
        clear_mem();
        imem[0]  = enc(O_ALUI, 1, 0, 0, 3'd0, 3);
        imem[1]  = enc(O_ALUI, 4, 0, 0, 3'd0, 4);
        imem[2]  = enc(O_BR,   0, 1, 4, 3'd0, 9);
        imem[3]  = enc(O_ST,   0, 0, 4, 3'd0, 22);
        imem[4]  = enc(O_JMP,  0, 0, 0, 3'd0, 12);
        imem[5]  = enc(O_ST,   0, 0, 1, 3'd0, 23);
        imem[12] = enc(O_ST,   0, 0, 1, 3'd0, 24);
        run(24, 99, 0, 99, 0);
        chk("R5 not-taken branch falls through", dmem[22], 32'd4);
        chk("R5 slot behind jump squashed", dmem[23], SENT);
        chk("R5 jump target store", dmem[24], 32'd3);
        chk("R5 jump target on fetch address", 32'(tr_pc[6]), 32'd12);
        chk("R10 one zero for jump only", 32'(zeros), 32'd1);

        // ---- three-cycle stall (R6, R10, R3) ----
        clear_mem();
        imem[0] = enc(O_ALUI, 1, 0, 0, 3'd0, 7);
        imem[1] = enc(O_ALUI, 2, 1, 0, 3'd0, 1);
        imem[2] = enc(O_ST,   0, 0, 2, 3'd0, 40);
        imem[3] = enc(O_ALU,  3, 1, 2, 3'd0, 0);
        imem[4] = enc(O_ST,   0, 0, 3, 3'd0, 41);
        run(24, 2, 3, 99, 0);
        chk("R6 fetch address held cycle 3", 32'(tr_pc[3]), 32'd2);
        chk("R6 fetch address held cycle 5", 32'(tr_pc[5]), 32'd2);
        chk("R6 fetch resumes", 32'(tr_pc[6]), 32'd3);
        chk("R10 zeros equal stall cycles", 32'(zeros), 32'd3);
        chk("R6 results after stall (a)", dmem[40], 32'd8);
        chk("R6 results after stall (b)", dmem[41], 32'd15);

        // ---- long stall drains pipeline (R7) ----
        clear_mem();
        imem[0] = enc(O_ALUI, 1, 0, 0, 3'd0, 6);
        imem[1] = enc(O_ST,   0, 0, 1, 3'd0, 50);
        imem[2] = enc(O_ST,   0, 0, 1, 3'd0, 51);
        run(20, 2, 6, 7, 50);
        chk("R7 older store done during stall", probe, 32'd6);
        chk("R7 no write late in stall", 32'(tr_we[7]), 32'h0);
        chk("R7 no write mid stall", 32'(tr_we[5]), 32'h0);
        chk("R7 unfetched store completes later", dmem[51], 32'd6);

        // ---- register zero and destination forcing (R9, R8) ----
        clear_mem();
        imem[0] = enc(O_ALUI, 0, 0, 0, 3'd0, 77);
        imem[1] = enc(O_ST,   0, 0, 0, 3'd0, 30);
        imem[2] = enc(O_ALUI, 5, 0, 0, 3'd0, 9);
        imem[3] = enc(O_ST,   5, 0, 0, 3'd0, 31);
        imem[4] = enc(O_ST,   0, 0, 5, 3'd0, 32);
        imem[5] = enc(O_BR,   5, 0, 5, 3'd0, 0);
        imem[6] = enc(O_ST,   0, 0, 5, 3'd0, 33);
        run(24, 99, 0, 99, 0);
        chk("R9 register zero ignores write", dmem[30], 32'd0);
        chk("R8 store with rd field leaves rd", dmem[32], 32'd9);
        chk("R8 branch with rd field leaves rd", dmem[33], 32'd9);
        chk("R10 no zeros without hazards", 32'(zeros), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule